// File: doc/BRIEF.md
# Serial Command and Write-Mode Controller

This block takes words from a three-pin serial link: a data pin, a shift clock and a framing strobe. Bits shift in MSB first on rising shift-clock edges, but only while the strobe is low. The rising edge of the strobe closes the frame, and the last eight bits received are taken as the word. The same strobe level also controls playback. While it stays high after a melody-start word, the block reports that playback is active. When the strobe falls, playback stops.

The block has three modes: idle, play and write. After reset it is idle, and the end-of-write word must be sent to reach play mode. In write mode, the first word after entry loads the tempo register. Every later word goes out as a write strobe with an address and data toward a 64-word melody RAM. The addresses count up from zero. Writes past the last address are dropped.

A sender may put an optional parity bit in front of each data word, which makes a nine-bit frame. Any data frame whose nine bits hold an even number of ones clears a good-flag. The write command sets this flag again. A parity-check word sent in play mode turns the data pin into an output. The pin then carries the good-flag for as long as the strobe stays high.

Top module: `serial_cmd_ctrl`

## Requirements
- R1: After reset, the block is idle: play_o, write_mode_o, sdio_oe_o and ram_we_o are low, and tempo_o and melody_sel_o are zero.
- R2: Bits shift in MSB first on rising sc_i edges while strobe_i is low. When more than 8 bits arrive in one frame, only the last 8 form the word.
- R3: Shift-clock edges that arrive while strobe_i is high change nothing. A later frame with no bits reuses the word last received.
- R4: Until the end-of-write word 10111111 has been received, a melody-start word 1000ssss has no effect: play_o stays low and melody_sel_o keeps its value.
- R5: In play mode, the word 1000ssss sets melody_sel_o to ssss and raises play_o while the strobe stays high. play_o drops within a few clocks after the strobe falls.
- R6: The write word 11011111 enters write mode (write_mode_o high) and sets the good-flag. The next data word loads its low 5 bits into tempo_o and produces no RAM write.
- R7: In write mode, every later word except 10111111 is written to RAM at addresses 0, 1, 2 and so on. This includes the end word 01011111 and the codes 11011111 and 01111111. melody_sel_o does not change in write mode.
- R8: At most 64 RAM writes happen per write session. Words beyond address 63 are discarded.
- R9: In write mode, the word 10111111 returns the block to play mode, and melody-start words then take effect again.
- R10: A 9-bit data frame with an even count of ones clears the good-flag. The word 01111111 in play mode drives sdio_o with the flag and raises sdio_oe_o while the strobe is high. sdio_oe_o is released after the strobe falls.
- R11: Frames of 8 bits or fewer never change the good-flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_i | input | 1 | Serial shift clock |
| strobe_i | input | 1 | Frame strobe and playback enable |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Good-flag value driven onto the pad |
| sdio_oe_o | output | 1 | Pad output enable |
| play_o | output | 1 | Playback active |
| melody_sel_o | output | 4 | Selected melody number |
| tempo_o | output | 5 | Tempo register |
| write_mode_o | output | 1 | Write mode active |
| ram_we_o | output | 1 | Melody RAM write strobe |
| ram_addr_o | output | 6 | Melody RAM write address |
| ram_wdata_o | output | 8 | Melody RAM write data |

## Verification
The hardest state to reach is the end of the 64-word RAM while the good-flag still reflects a mix of frame lengths. The bench gets there with one long write session of seventy nine-bit frames, each with correct parity. The payloads are computed arithmetically, and the session includes the end word and the other command codes sent as data. A bench-side RAM model then shows exactly 64 stored words in order. Separate sessions then fail parity on the tempo word, or send short frames with even payloads. Each session ends with a parity-check frame so the flag can be read back on the data pin.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int WORD_W  = 8;
  localparam int FRAME_W = WORD_W + 1;
  localparam int SEL_W   = 4;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PLAY  = 2'd1,
    MODE_WRITE = 2'd2
  } mode_e;

  localparam logic [WORD_W-1:0] CODE_WRITE = 8'b1101_1111;
  localparam logic [WORD_W-1:0] CODE_EOW   = 8'b1011_1111;
  localparam logic [WORD_W-1:0] CODE_PCHK  = 8'b0111_1111;
  localparam logic [WORD_W-SEL_W-1:0] CODE_MEL_PFX = 4'b1000;

  typedef struct packed {
    logic              vld;
    logic [WORD_W-1:0] word;
    logic              long_frame;
    logic              odd;
  } frame_t;
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '0;
      else         pipe <= {pipe[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/sc_shift_rx.sv
module sc_shift_rx
  import serial_cmd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sc_rise_i,
  input  logic   strb_lvl_i,
  input  logic   strb_rise_i,
  input  logic   data_i,
  output frame_t frame_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LONG = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (strb_rise_i) begin
      cnt <= '0;
    end else if (sc_rise_i && !strb_lvl_i) begin
      shreg <= {shreg[FRAME_W-2:0], data_i};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    frame_o.vld        = strb_rise_i;
    frame_o.word       = shreg[WORD_W-1:0];
    frame_o.long_frame = (cnt >= CNT_LONG);
    frame_o.odd        = ^shreg;
  end
endmodule

// File: rtl/sc_cmd_fsm.sv
module sc_cmd_fsm
  import serial_cmd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int TEMPO_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  frame_t             frame_i,
  input  logic               strb_fall_i,
  output mode_e              mode_o,
  output logic               play_o,
  output logic               chk_o,
  output logic               good_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [TEMPO_W-1:0] tempo_o,
  output logic               we_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [WORD_W-1:0]  wdata_o
);
  mode_e            mode_q;
  logic             tempo_pend;
  logic [ADDR_W:0]  waddr;
  logic             ram_full;
  logic             is_mel;

  assign ram_full = waddr[ADDR_W];
  assign is_mel   = (frame_i.word[WORD_W-1:SEL_W] == CODE_MEL_PFX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_IDLE;
      play_o     <= 1'b0;
      chk_o      <= 1'b0;
      good_o     <= 1'b0;
      sel_o      <= '0;
      tempo_o    <= '0;
      tempo_pend <= 1'b0;
      waddr      <= '0;
      we_o       <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
    end else begin
      we_o <= 1'b0;
      if (strb_fall_i) begin
        play_o <= 1'b0;
        chk_o  <= 1'b0;
      end
      if (frame_i.vld) begin
        unique case (mode_q)
          MODE_IDLE, MODE_PLAY: begin
            if (frame_i.word == CODE_WRITE) begin
              mode_q     <= MODE_WRITE;
              good_o     <= 1'b1;
              tempo_pend <= 1'b1;
              waddr      <= '0;
            end else if (frame_i.word == CODE_EOW) begin
              mode_q <= MODE_PLAY;
            end else if (mode_q == MODE_PLAY) begin
              if (frame_i.word == CODE_PCHK) begin
                chk_o <= 1'b1;
              end else if (is_mel) begin
                sel_o  <= frame_i.word[SEL_W-1:0];
                play_o <= 1'b1;
              end
            end
          end
          MODE_WRITE: begin
            if (frame_i.word == CODE_EOW) begin
              mode_q <= MODE_PLAY;
            end else begin
              // parity only judged on 9+ bit frames
              if (frame_i.long_frame && !frame_i.odd) good_o <= 1'b0;
              if (tempo_pend) begin
                tempo_o    <= frame_i.word[TEMPO_W-1:0];
                tempo_pend <= 1'b0;
              end else if (!ram_full) begin
                we_o    <= 1'b1;
                addr_o  <= waddr[ADDR_W-1:0];
                wdata_o <= frame_i.word;
                waddr   <= waddr + 1'b1;
              end
            end
          end
          default: mode_q <= MODE_IDLE;
        endcase
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/serial_cmd_ctrl.sv
module serial_cmd_ctrl
  import serial_cmd_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int TEMPO_W     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sc_i,
  input  logic               strobe_i,
  input  logic               sdio_i,
  output logic               sdio_o,
  output logic               sdio_oe_o,
  output logic               play_o,
  output logic [SEL_W-1:0]   melody_sel_o,
  output logic [TEMPO_W-1:0] tempo_o,
  output logic               write_mode_o,
  output logic               ram_we_o,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic [WORD_W-1:0]  ram_wdata_o
);
  logic [2:0] sync_q;
  logic       sc_s, strb_s, data_s;
  logic       sc_prev, strb_prev;
  logic       sc_rise, strb_rise, strb_fall;
  frame_t     frame;
  mode_e      mode;
  logic       chk, good;

  sc_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdio_i, strobe_i, sc_i}),
    .q_o   (sync_q)
  );
  assign {data_s, strb_s, sc_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_prev   <= 1'b0;
      strb_prev <= 1'b0;
    end else begin
      sc_prev   <= sc_s;
      strb_prev <= strb_s;
    end
  end

  assign sc_rise   = sc_s & ~sc_prev;
  assign strb_rise = strb_s & ~strb_prev;
  assign strb_fall = ~strb_s & strb_prev;

  sc_shift_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sc_rise_i  (sc_rise),
    .strb_lvl_i (strb_s),
    .strb_rise_i(strb_rise),
    .data_i     (data_s),
    .frame_o    (frame)
  );

  sc_cmd_fsm #(.ADDR_W(ADDR_W), .TEMPO_W(TEMPO_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame),
    .strb_fall_i(strb_fall),
    .mode_o     (mode),
    .play_o     (play_o),
    .chk_o      (chk),
    .good_o     (good),
    .sel_o      (melody_sel_o),
    .tempo_o    (tempo_o),
    .we_o       (ram_we_o),
    .addr_o     (ram_addr_o),
    .wdata_o    (ram_wdata_o)
  );

  assign write_mode_o = (mode == MODE_WRITE);
  assign sdio_oe_o    = chk;
  assign sdio_o       = chk & good;
endmodule

// File: rtl/serial_cmd_ctrl_chk.sv
module serial_cmd_ctrl_chk #(
  parameter int TEMPO_W = 5,
  parameter int SEL_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               strb_s,
  input logic               play_o,
  input logic               sdio_oe_o,
  input logic               write_mode_o,
  input logic               ram_we_o,
  input logic [TEMPO_W-1:0] tempo_o,
  input logic [SEL_W-1:0]   melody_sel_o
);
  // R6
  tempo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_mode_o |=> $stable(tempo_o));
  // R7
  ram_we_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> write_mode_o);
  // R10
  pin_turn_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> (!play_o && !write_mode_o));
  // R5
  strobe_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_s) |=> (!play_o && !sdio_oe_o));
  // R5
  sel_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(melody_sel_o) |-> play_o);
endmodule

bind serial_cmd_ctrl serial_cmd_ctrl_chk #(.TEMPO_W(TEMPO_W), .SEL_W(4)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .strb_s      (strb_s),
  .play_o      (play_o),
  .sdio_oe_o   (sdio_oe_o),
  .write_mode_o(write_mode_o),
  .ram_we_o    (ram_we_o),
  .tempo_o     (tempo_o),
  .melody_sel_o(melody_sel_o)
);

// File: tb/tb_serial_cmd_ctrl.sv
module tb_serial_cmd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sc_i = 1'b0, strobe_i = 1'b0, sdio_i = 1'b0;
  logic       sdio_o, sdio_oe_o, play_o, write_mode_o, ram_we_o;
  logic [3:0] melody_sel_o;
  logic [4:0] tempo_o;
  logic [5:0] ram_addr_o;
  logic [7:0] ram_wdata_o;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  logic [7:0] mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .sc_i(sc_i), .strobe_i(strobe_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .play_o(play_o), .melody_sel_o(melody_sel_o),
    .tempo_o(tempo_o), .write_mode_o(write_mode_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o)
  );

  // external RAM model
  always @(posedge clk) begin
    if (ram_we_o) begin
      mem[ram_addr_o] <= ram_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_in(input logic [15:0] b, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      sdio_i = b[k];
      wait_clk(3);
      sc_i = 1'b1;
      wait_clk(3);
      sc_i = 1'b0;
      wait_clk(2);
    end
  endtask

  task automatic frame(input logic [15:0] b, input int n);
    shift_in(b, n);
    strobe_i = 1'b1;
    wait_clk(8);
  endtask

  task automatic release_strobe();
    strobe_i = 1'b0;
    wait_clk(8);
  endtask

  task automatic word(input logic [7:0] w);
    frame({8'h00, w}, 8);
    release_strobe();
  endtask

  function automatic logic [8:0] odd9(input logic [7:0] d);
    return {~^d, d};
  endfunction

  function automatic logic [7:0] dword(input int i);
    logic [7:0] v;
    v = 8'((i * 37 + 11) & 255);
    if (v == 8'hBF) v = 8'hBE;
    if (i == 5) v = 8'h5F;
    if (i == 6) v = 8'hDF;
    if (i == 7) v = 8'h7F;
    if (i == 8) v = 8'h84;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_ni = 1'b1;
    wait_clk(4);
    // R1 reset state
    check(!play_o && !write_mode_o && !sdio_oe_o && !ram_we_o, "R1 ctrl", 
          {play_o, write_mode_o, sdio_oe_o, ram_we_o}, 0);
    check(tempo_o == 0 && melody_sel_o == 0, "R1 regs", {tempo_o, melody_sel_o}, 0);

    // R4 melody start ignored before play mode
    frame(16'h0085, 8);
    check(play_o == 1'b0, "R4 play", play_o, 0);
    check(melody_sel_o == 4'h0, "R4 sel", melody_sel_o, 0);
    release_strobe();

    word(8'hBF);
    check(write_mode_o == 1'b0, "R9 idle to play", write_mode_o, 0);

    // R5 sweep every selector
    for (int s = 0; s < 16; s++) begin
      frame({12'h008, 4'(s)}, 8);
      check(play_o == 1'b1, "R5 play high", play_o, 1);
      check(melody_sel_o == 4'(s), "R5 sel", melody_sel_o, s);
      release_strobe();
      check(play_o == 1'b0, "R5 play low", play_o, 0);
    end

    // R2 over-long frame keeps last 8 bits
    frame(16'h0F8A, 12);
    check(melody_sel_o == 4'hA, "R2 long frame", melody_sel_o, 4'hA);
    release_strobe();

    // R3 clocks while strobe high ignored
    frame(16'h0083, 8);
    for (int k = 7; k >= 0; k--) begin
      sdio_i = k[0];
      wait_clk(3); sc_i = 1'b1; wait_clk(3); sc_i = 1'b0; wait_clk(2);
    end
    release_strobe();
    frame(16'h0000, 0);
    check(melody_sel_o == 4'h3 && play_o, "R3 retained word", melody_sel_o, 3);
    release_strobe();

    // R6 write mode, tempo word with good parity
    frame(16'h00DF, 8);
    check(write_mode_o == 1'b1, "R6 enter write", write_mode_o, 1);
    release_strobe();
    frame({7'h0, odd9(8'h16)}, 9);
    release_strobe();
    check(tempo_o == 5'h16, "R6 tempo", tempo_o, 5'h16);
    check(wr_cnt == 0, "R6 no ram write", wr_cnt, 0);

    // R7 R8 long session, all odd parity
    for (int i = 0; i < 70; i++) begin
      frame({7'h0, odd9(dword(i))}, 9);
      release_strobe();
    end
    check(wr_cnt == 64, "R8 write count", wr_cnt, 64);
    for (int i = 0; i < 64; i++)
      check(mem[i] == dword(i), "R7 ram data", mem[i], dword(i));
    check(melody_sel_o == 4'h3, "R7 sel held", melody_sel_o, 3);
    check(write_mode_o == 1'b1, "R7 still write", write_mode_o, 1);

    word(8'hBF);
    check(write_mode_o == 1'b0, "R9 exit write", write_mode_o, 0);
    frame(16'h007F, 8);
    check(sdio_oe_o && sdio_o, "R10 flag good", {sdio_oe_o, sdio_o}, 3);
    release_strobe();
    check(sdio_oe_o == 1'b0, "R10 release", sdio_oe_o, 0);
    frame(16'h008C, 8);
    check(play_o && melody_sel_o == 4'hC, "R9 play after exit", melody_sel_o, 4'hC);
    release_strobe();

    // R10 even parity on tempo clears flag
    word(8'hDF);
    frame({7'h0, ^8'h09, 8'h09}, 9);
    release_strobe();
    frame({7'h0, odd9(8'h21)}, 9);
    release_strobe();
    word(8'hBF);
    check(tempo_o == 5'h09, "R6 tempo second", tempo_o, 5'h09);
    frame(16'h007F, 8);
    check(sdio_oe_o && !sdio_o, "R10 flag bad", {sdio_oe_o, sdio_o}, 2);
    release_strobe();

    // R11 short frames never judged; address restarts at 0
    word(8'hDF);
    word(8'h03);
    word(8'h03);
    word(8'h60);
    word(8'hBF);
    check(mem[0] == 8'h03 && mem[1] == 8'h60, "R7 addr restart", {mem[0], mem[1]}, 16'h0360);
    check(tempo_o == 5'h03, "R6 tempo third", tempo_o, 3);
    frame(16'h007F, 8);
    check(sdio_oe_o && sdio_o, "R11 flag kept", {sdio_oe_o, sdio_o}, 3);
    release_strobe();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule